// File: doc/BRIEF.md
# Pad GPIO Controller with Edge Interrupts

A byte-wide register-mapped controller for thirteen general-purpose pins. Every pin owns a pad-control register (direction, push-pull or open-drain drive, pull resistor enable, pull strength and direction, output value) and an edge-control register. The edge-control register returns the pin level after a two-flop synchronizer and selects which transitions raise an interrupt. Pins 0–6 report into a first status/mask pair and pins 7–12 into a second. Status bits are cleared by writing ones. A single interrupt line is high while any unmasked status bit is set.

Host access is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. Pad-control outputs go straight to the pad ring. Analog pad behaviour lies outside the block.

Top module: `gpio_pad_irq`

## Requirements
- R1: After reset every pad-control register reads 0x00, every edge-control register has bits 2:1 = 0, status reads 0x00 in both groups, mask reads 0x7F (group 0) and 0x3F (group 1), and `pad_oe`, `pull_en` and `irq` are 0.
- R2: Pad-control register of pin n sits at 0x4E44+n and reads back bits 5:0. Bit 5 = output direction. Bit 4 = push-pull when 1. Bit 3 drives `pull_en`. Bit 1 drives `pull_up`. Bit 2 drives `pull_weak` (50k when 1, 2k when 0). Bit 0 = output value.
- R3: With direction output and push-pull, `pad_oe`=1 and `pad_out` follows the value bit. With open-drain, a value of 0 gives `pad_oe`=1 and `pad_out`=0, and a value of 1 releases the pad (`pad_oe`=0). With direction input, `pad_oe`=0.
- R4: Bit 0 of the edge-control register of pin n (at 0x4E51+n) shows the pin level exactly two clock edges after the pin changes.
- R5: Edge-control bits 2:1 select detection: 0 none, 1 falling, 2 rising, 3 both. A selected edge sets the pin's status bit on the third clock edge after the pin changes, and not earlier. An unselected edge sets nothing.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: An edge whose status update falls in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R8: `irq` is high exactly when some status bit is set with its mask bit 0. A mask bit of 1 blocks that pin.
- R9: Unmapped addresses read 0 and writes to them change nothing. Unused upper bits of every register read 0.
- R10: Status/mask group 0 (0x4E0B / 0x4E19) carries pins 0–6 in bits 6:0. Group 1 (0x4E0C / 0x4E1A) carries pins 7–12 in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pin_in | input | 13 | Pad input levels |
| pad_out | output | 13 | Pad drive value |
| pad_oe | output | 13 | Pad output enable |
| pull_en | output | 13 | Pull resistor enable |
| pull_up | output | 13 | Pull direction, 1 = up |
| pull_weak | output | 13 | Pull strength, 1 = 50k |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can land in the same cycle: an edge-detect status set and a host write-one-to-clear of the same status bit. The bench provokes this by toggling a pin configured for both edges so that the first edge has already set the status bit. It then issues the clear write on the exact clock edge where the second edge's status update commits, which is the third edge after the pin moves. The read that follows must still show the bit set and `irq` high. A later plain clear must then empty it.

// File: rtl/gpio_pad_irq.sv
module gpio_pad_irq #(
  parameter int NPINS = 13,
  parameter int G0_PINS = 7,
  parameter int AW = 16,
  parameter logic [AW-1:0] PAD_BASE = 16'h4E44,
  parameter logic [AW-1:0] EDGE_BASE = 16'h4E51,
  parameter logic [AW-1:0] STS_BASE = 16'h4E0B,
  parameter logic [AW-1:0] MSK_BASE = 16'h4E19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pull_en,
  output logic [NPINS-1:0] pull_up,
  output logic [NPINS-1:0] pull_weak,
  output logic             irq
);
  localparam int G1_PINS = NPINS - G0_PINS;

  logic [NPINS-1:0] sync1, sync2, sync3, hit, sts, msk, clr;
  logic [NPINS-1:0][7:0] rd_pin;
  logic [7:0] rd_grp;
  logic unused_wbits;

  assign unused_wbits = &{1'b0, reg_wdata[7:6]};

  wire sts0_wr = reg_wr && reg_addr == STS_BASE;
  wire sts1_wr = reg_wr && reg_addr == STS_BASE + AW'(1);
  wire msk0_wr = reg_wr && reg_addr == MSK_BASE;
  wire msk1_wr = reg_wr && reg_addr == MSK_BASE + AW'(1);

  assign clr = {sts1_wr ? reg_wdata[G1_PINS-1:0] : {G1_PINS{1'b0}},
                sts0_wr ? reg_wdata[G0_PINS-1:0] : {G0_PINS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) msk <= '1;
    else begin
      if (msk0_wr) msk[G0_PINS-1:0] <= reg_wdata[G0_PINS-1:0];
      if (msk1_wr) msk[NPINS-1:G0_PINS] <= reg_wdata[G1_PINS-1:0];
    end

  assign irq = |(sts & ~msk);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [5:0] pad_q;
    logic [1:0] esel_q;
    wire pad_sel  = reg_addr == PAD_BASE + AW'(i);
    wire edge_sel = reg_addr == EDGE_BASE + AW'(i);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pad_q  <= '0;
        esel_q <= '0;
      end else begin
        if (reg_wr && pad_sel)  pad_q  <= reg_wdata[5:0];
        if (reg_wr && edge_sel) esel_q <= reg_wdata[2:1];
      end

    assign hit[i] = (esel_q[1] & sync2[i] & ~sync3[i]) |
                    (esel_q[0] & ~sync2[i] & sync3[i]);

    assign pad_oe[i]    = pad_q[5] & (pad_q[4] | ~pad_q[0]);
    assign pad_out[i]   = pad_q[4] & pad_q[0];
    assign pull_en[i]   = pad_q[3];
    assign pull_up[i]   = pad_q[1];
    assign pull_weak[i] = pad_q[2];

    assign rd_pin[i] = pad_sel  ? {2'b00, pad_q} :
                       edge_sel ? {5'b0, esel_q, sync2[i]} : 8'h00;

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[i] && !pad_q[4]) |-> !pad_out[i]);                       // R3
    AST_STS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[i]) |-> $past(sync2[i] ^ sync3[i]));                   // R5
    AST_STS_FALLS_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[i]) |-> $past(reg_wr));                                // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> sts[i]);                                              // R7
  end

  always_comb begin
    rd_grp = 8'h00;
    if (reg_addr == STS_BASE)               rd_grp = {{(8-G0_PINS){1'b0}}, sts[G0_PINS-1:0]};
    if (reg_addr == STS_BASE + AW'(1))      rd_grp = {{(8-G1_PINS){1'b0}}, sts[NPINS-1:G0_PINS]};
    if (reg_addr == MSK_BASE)               rd_grp = {{(8-G0_PINS){1'b0}}, msk[G0_PINS-1:0]};
    if (reg_addr == MSK_BASE + AW'(1))      rd_grp = {{(8-G1_PINS){1'b0}}, msk[NPINS-1:G0_PINS]};
    reg_rdata = rd_grp;
    for (int k = 0; k < NPINS; k++) reg_rdata = reg_rdata | rd_pin[k];
  end

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk) |-> !irq);                                                  // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0));                                              // R8
endmodule

// File: tb/gpio_pad_irq_tb.sv
module gpio_pad_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_addr = 16'h0;
  logic [7:0] reg_wdata = 8'h0;
  logic [7:0] reg_rdata;
  logic [12:0] pins = '0;
  logic [12:0] pad_out, pad_oe, pull_en, pull_up, pull_weak;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int kind; logic [12:0] exp; string tag; } item_t;
  item_t q[$];
  event mon_ev;

  localparam logic [15:0] PAD = 16'h4E44, EDG = 16'h4E51, STS = 16'h4E0B, MSK = 16'h4E19;

  always #2 clk = ~clk;

  gpio_pad_irq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pins),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
    .pull_up(pull_up), .pull_weak(pull_weak), .irq(irq)
  );

  initial forever begin
    @(mon_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [12:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {5'b0, reg_rdata};
        1: act = pad_oe;
        2: act = pad_out;
        3: act = pull_en;
        4: act = pull_up;
        5: act = pull_weak;
        default: act = {12'b0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(int kind, logic [15:0] a, logic [12:0] e, string tag);
    item_t it;
    reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    ->mon_ev;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(0, PAD, 13'h00, "R1 pad0");
    chk(0, PAD + 12, 13'h00, "R1 pad12");
    chk(0, EDG + 4, 13'h00, "R1 edge4");
    chk(0, MSK, 13'h7F, "R1 mask0");
    chk(0, MSK + 1, 13'h3F, "R1 mask1");
    chk(0, STS, 13'h00, "R1 sts0");
    chk(1, 0, 13'h0, "R1 pad_oe");
    chk(3, 0, 13'h0, "R1 pull_en");
    chk(6, 0, 13'h0, "R1 irq");

    // R2 field mapping, upper bits dropped (R9)
    wr(PAD + 3, 8'hFF);
    chk(0, PAD + 3, 13'h3F, "R2 R9 pad3 readback");
    wr(PAD + 11, 8'h2A);
    chk(3, 0, 13'h0808, "R2 pull_en");
    chk(4, 0, 13'h0808, "R2 pull_up");
    chk(5, 0, 13'h0008, "R2 pull_weak");
    // R3 drive modes
    chk(1, 0, 13'h0808, "R3 oe pp1 od0");
    chk(2, 0, 13'h0008, "R3 out");
    wr(PAD + 11, 8'h23);
    chk(1, 0, 13'h0008, "R3 od release");
    wr(PAD + 3, 8'h10);
    chk(1, 0, 13'h0000, "R3 input no drive");
    wr(PAD + 3, 8'h3E);
    chk(1, 0, 13'h0008, "R3 pp drive low oe");
    chk(2, 0, 13'h0000, "R3 pp drive low out");

    // R4 synchronizer latency
    pins[5] = 1'b1;
    step(1);
    chk(0, EDG + 5, 13'h00, "R4 level one edge");
    chk(0, EDG + 5, 13'h01, "R4 level two edges");

    // R5 rising on pin 0
    wr(EDG, 8'h04);
    pins[0] = 1'b1;
    step(2);
    chk(0, STS, 13'h00, "R5 rise early");
    chk(0, STS, 13'h01, "R5 rise set R10");
    // R5 falling-only pin 9 ignores rise
    wr(EDG + 9, 8'h02);
    pins[9] = 1'b1;
    step(4);
    chk(0, STS + 1, 13'h00, "R5 rise ignored");
    pins[9] = 1'b0;
    step(2);
    chk(0, STS + 1, 13'h00, "R5 fall early");
    chk(0, STS + 1, 13'h04, "R5 fall set R10");
    // both edges pin 12
    wr(EDG + 12, 8'h06);
    pins[12] = 1'b1;
    step(3);
    chk(0, STS + 1, 13'h24, "R5 both rise R10");

    // R8 masking
    chk(6, 0, 13'h0, "R8 all masked");
    wr(MSK + 1, 8'hDF);
    chk(0, MSK + 1, 13'h1F, "R9 mask1 upper");
    chk(6, 0, 13'h1, "R8 pin12 unmasked");
    wr(MSK, 8'hFF);
    chk(0, MSK, 13'h7F, "R9 mask0 upper");

    // R6 clearing
    wr(STS + 1, 8'h00);
    chk(0, STS + 1, 13'h24, "R6 zero keeps");
    wr(STS + 1, 8'h20);
    chk(0, STS + 1, 13'h04, "R6 one clears");
    chk(6, 0, 13'h0, "R8 cleared irq");

    // R7 edge coincides with clear: set pin12 first by a falling edge
    pins[12] = 1'b0;
    step(3);
    chk(0, STS + 1, 13'h24, "R7 preset");
    pins[12] = 1'b1;
    step(2);
    wr(STS + 1, 8'h20);
    chk(0, STS + 1, 13'h24, "R7 set wins");
    chk(6, 0, 13'h1, "R7 irq held");
    wr(STS + 1, 8'h3F);
    chk(0, STS + 1, 13'h00, "R7 later clear");

    // R10 pin 7 lands in group 1 bit 0, pin 6 in group 0 bit 6
    wr(EDG + 7, 8'h04);
    wr(EDG + 6, 8'h04);
    pins[7] = 1'b1;
    pins[6] = 1'b1;
    step(3);
    chk(0, STS + 1, 13'h01, "R10 pin7");
    chk(0, STS, 13'h41, "R10 pin6");

    // R9 unmapped
    wr(16'h4E30, 8'hFF);
    chk(0, 16'h4E30, 13'h00, "R9 unmapped read");
    chk(0, 16'h4E43, 13'h00, "R9 below pad window");
    chk(0, 16'h4E5E, 13'h00, "R9 above edge window");
    wr(EDG + 5, 8'hF8);
    chk(0, EDG + 5, 13'h01, "R9 edge upper bits");
    chk(0, PAD + 3, 13'h3E, "R9 pad3 untouched");
    chk(0, STS, 13'h41, "R9 sts untouched");

    step(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule